// File: doc/BRIEF.md
# Host Port Pin Function Multiplexer

This unit sits between the pads of a host interface port and the host protocol core. Every pin of the port is shared. It either carries a host-bus signal (an address line, the chip select, a request output or an acknowledge input) or works as a general-purpose I/O line. Three programmable registers on a small register bus set the choice, together with two static mode inputs. The first mode input says whether the host bus is multiplexed. The second says whether one or two host request lines are used.

A port control register holds a master host-enable bit and one enable bit for each shareable function. A direction register and a data register serve the pins that are left as GPIO. The unit drives an output-enable and an output value for every pin. It passes pin levels to the host core only on pins that currently hold a host input function. On GPIO reads it returns live input levels or stored output values.

Five pins have dedicated roles. Pin 0 is address 8 or low address 1, pin 1 is address 9 or low address 2, pin 2 is chip select or address 10, pin 3 is the request or transmit-request line, and pin 4 is the acknowledge or receive-request line. The parameter `EXTRA_W` adds further pins, numbered from 5 upward. These become host inputs as soon as the host function is enabled.

Top module: `host_pin_mux`

## Requirements
- R1: After reset, all three registers read zero and every pin is a GPIO input: `pin_oe` is all zero and `core_pin_in` is zero.
- R2: A write takes effect at the rising clock edge while `reg_we` is high, and reads are combinational. Address 0 selects the control register, address 1 the direction register and address 2 the data register. Address 3 reads zero. The control register stores only bits 1 to 6, so bit 0, bit 7 and all higher bits read zero whatever is written.
- R3: While control bit 6 (host enable) is clear, every pin is GPIO.
- R4: With host enable set, pin 0 is a host input when `bus_mux_mode` is 0 (low address line) or when control bit 1 is set. Otherwise it is GPIO. Pin 1 behaves the same way with control bit 2. Bits 1 and 2 have no effect when `bus_mux_mode` is 0.
- R5: With host enable set, pin 2 is a host input (chip select, or address 10 in multiplexed mode) when control bit 3 is set, and GPIO when it is clear. This holds in both bus modes.
- R6: With host enable and control bit 4 (request enable) set, and `dual_request` at 0, pin 3 is a driven output carrying `core_req_a`. Pin 4 is then a host input if control bit 5 (acknowledge enable) is set, and GPIO if it is clear.
- R7: With host enable and request enable set, and `dual_request` at 1, pin 3 drives `core_req_a` and pin 4 drives `core_req_b`. Control bit 5 is ignored.
- R8: With host enable set and request enable clear, pins 3 and 4 are both GPIO.
- R9: A GPIO pin has `pin_oe` equal to its direction bit and `pin_out` equal to its data bit. A host input pin has `pin_oe` and `pin_out` at 0. A host output pin has `pin_oe` at 1.
- R10: Reading the data register returns, for each pin, the stored bit if it is a GPIO output, the live `pin_in` level if it is a GPIO input, and 0 if it holds a host function.
- R11: `core_pin_in` carries `pin_in` on host input pins and 0 on all other pins.
- R12: Each extra pin (index 5 and up) is a host input whenever host enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 direction, 2 data) |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Combinational read data |
| bus_mux_mode | input | 1 | 1 = multiplexed host bus |
| dual_request | input | 1 | 1 = separate transmit and receive request lines |
| core_req_a | input | 1 | Request (or transmit request) from the host core |
| core_req_b | input | 1 | Receive request from the host core |
| core_pin_in | output | 5+EXTRA_W | Pin levels on host input pins, 0 elsewhere |
| pin_in | input | 5+EXTRA_W | Pad input levels |
| pin_oe | output | 5+EXTRA_W | Pad output enables |
| pin_out | output | 5+EXTRA_W | Pad output values |

## Verification
The bench builds the block with the default `EXTRA_W` of 3 and `BUS_W` of 16. That gives eight pins, so every dedicated role and several always-host pins are covered. It also leaves eight bus bits above the pins, which must always read zero. Random control values, together with random flips of the bus-mode and request-mode inputs, reach each precedence case, including acknowledge enable set with request enable clear and address enables set in non-multiplexed mode. Random pad levels then show that live GPIO inputs and host pins read back correctly.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

  typedef enum logic [1:0] {
    ROLE_GPIO     = 2'd0,
    ROLE_HOST_IN  = 2'd1,
    ROLE_HOST_OUT = 2'd2
  } pin_role_e;

  localparam int CTL_W     = 8;
  localparam int BIT_A8    = 1;
  localparam int BIT_A9    = 2;
  localparam int BIT_CS    = 3;
  localparam int BIT_REQ   = 4;
  localparam int BIT_ACK   = 5;
  localparam int BIT_HOST  = 6;
  localparam logic [CTL_W-1:0] CTL_KEEP = 8'h7E;

  localparam int PIN_A8     = 0;
  localparam int PIN_A9     = 1;
  localparam int PIN_CS     = 2;
  localparam int PIN_REQ    = 3;
  localparam int PIN_ACK    = 4;
  localparam int FIXED_PINS = 5;

  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_DIR = 2'd1;
  localparam logic [1:0] ADDR_DAT = 2'd2;

  // Role of one pin from control bits and the two mode flags
  function automatic pin_role_e role_for_pin(int idx, logic [CTL_W-1:0] ctl,
                                             logic mux, logic dual);
    pin_role_e r;
    r = ROLE_GPIO;
    if (ctl[BIT_HOST]) begin
      if (idx == PIN_A8)
        r = (!mux || ctl[BIT_A8]) ? ROLE_HOST_IN : ROLE_GPIO;
      else if (idx == PIN_A9)
        r = (!mux || ctl[BIT_A9]) ? ROLE_HOST_IN : ROLE_GPIO;
      else if (idx == PIN_CS)
        r = ctl[BIT_CS] ? ROLE_HOST_IN : ROLE_GPIO;
      else if (idx == PIN_REQ)
        r = ctl[BIT_REQ] ? ROLE_HOST_OUT : ROLE_GPIO;
      else if (idx == PIN_ACK) begin
        if (!ctl[BIT_REQ])     r = ROLE_GPIO;
        else if (dual)         r = ROLE_HOST_OUT;
        else if (ctl[BIT_ACK]) r = ROLE_HOST_IN;
        else                   r = ROLE_GPIO;
      end else
        r = ROLE_HOST_IN;
    end
    return r;
  endfunction

endpackage

// File: rtl/hpm_regs.sv
module hpm_regs
  import hpm_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] dat_q
);

  logic wr_ctl, wr_dir, wr_dat;
  logic unused_wdata;

  assign wr_ctl = we && (addr == ADDR_CTL);
  assign wr_dir = we && (addr == ADDR_DIR);
  assign wr_dat = we && (addr == ADDR_DAT);
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= wdata[CTL_W-1:0] & CTL_KEEP;
      if (wr_dir) dir_q <= wdata[NPINS-1:0];
      if (wr_dat) dat_q <= wdata[NPINS-1:0];
    end
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata[NPINS-1:0]));

  assert_dat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dat |=> $stable(dat_q));

endmodule

// File: rtl/hpm_role_decode.sv
module hpm_role_decode
  import hpm_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CTL_W-1:0]   ctl,
  input  logic               mux,
  input  logic               dual,
  output logic [2*NPINS-1:0] roles
);

  logic host_on;
  logic req_on;
  assign host_on = ctl[BIT_HOST];
  assign req_on  = ctl[BIT_HOST] && ctl[BIT_REQ];

  for (genvar i = 0; i < NPINS; i++) begin : g_role
    assign roles[2*i +: 2] = role_for_pin(i, ctl, mux, dual);

    assert_host_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !host_on |-> roles[2*i +: 2] == ROLE_GPIO);
  end

  assert_dual_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_on && dual) |-> roles[2*PIN_ACK +: 2] == ROLE_HOST_OUT);

  assert_req_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_on && !req_on) |->
      (roles[2*PIN_ACK +: 2] == ROLE_GPIO && roles[2*PIN_REQ +: 2] == ROLE_GPIO));

endmodule

// File: rtl/hpm_pin_cell.sv
module hpm_pin_cell
  import hpm_pkg::*;
(
  input  logic [1:0] role,
  input  logic       dir_bit,
  input  logic       dat_bit,
  input  logic       pad_in,
  input  logic       core_out,
  output logic       pad_oe,
  output logic       pad_out,
  output logic       rd_bit,
  output logic       core_in
);

  always_comb begin
    pad_oe  = 1'b0;
    pad_out = 1'b0;
    rd_bit  = 1'b0;
    core_in = 1'b0;
    case (pin_role_e'(role))
      ROLE_HOST_OUT: begin
        pad_oe  = 1'b1;
        pad_out = core_out;
      end
      ROLE_HOST_IN: begin
        core_in = pad_in;
      end
      default: begin
        pad_oe  = dir_bit;
        pad_out = dat_bit;
        rd_bit  = dir_bit ? dat_bit : pad_in;
      end
    endcase
  end

endmodule

// File: rtl/host_pin_mux.sv
module host_pin_mux
  import hpm_pkg::*;
#(
  parameter int EXTRA_W = 3,
  parameter int BUS_W   = 16,
  localparam int NPINS  = FIXED_PINS + EXTRA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             bus_mux_mode,
  input  logic             dual_request,
  input  logic             core_req_a,
  input  logic             core_req_b,
  output logic [NPINS-1:0] core_pin_in,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_out
);

  logic [CTL_W-1:0]   ctl_q;
  logic [NPINS-1:0]   dir_q;
  logic [NPINS-1:0]   dat_q;
  logic [2*NPINS-1:0] roles;
  logic [NPINS-1:0]   rd_bits;
  logic [NPINS-1:0]   core_drive;

  hpm_regs #(.BUS_W(BUS_W), .NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ctl_q(ctl_q), .dir_q(dir_q), .dat_q(dat_q)
  );

  hpm_role_decode #(.NPINS(NPINS)) u_decode (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .mux(bus_mux_mode),
    .dual(dual_request), .roles(roles)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (i == PIN_REQ) begin : g_drv_a
      assign core_drive[i] = core_req_a;
    end else if (i == PIN_ACK) begin : g_drv_b
      assign core_drive[i] = core_req_b;
    end else begin : g_drv_none
      assign core_drive[i] = 1'b0;
    end

    hpm_pin_cell u_cell (
      .role(roles[2*i +: 2]), .dir_bit(dir_q[i]), .dat_bit(dat_q[i]),
      .pad_in(pin_in[i]), .core_out(core_drive[i]),
      .pad_oe(pin_oe[i]), .pad_out(pin_out[i]), .rd_bit(rd_bits[i]),
      .core_in(core_pin_in[i])
    );

    assert_host_in_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (roles[2*i +: 2] == ROLE_HOST_IN) |-> (!pin_oe[i] && !pin_out[i]));

    assert_gpio_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (roles[2*i +: 2] == ROLE_GPIO) |-> (pin_oe[i] == dir_q[i]));

    assert_core_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (roles[2*i +: 2] != ROLE_HOST_IN) |-> !core_pin_in[i]);

    assert_host_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (roles[2*i +: 2] != ROLE_GPIO) |-> !rd_bits[i]);
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTL: reg_rdata = BUS_W'(ctl_q);
      ADDR_DIR: reg_rdata = BUS_W'(dir_q);
      ADDR_DAT: reg_rdata = BUS_W'(rd_bits);
      default:  reg_rdata = '0;
    endcase
  end

  assert_ctl_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_CTL) |-> (!reg_rdata[7] && !reg_rdata[0]));

  assert_req_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[BIT_HOST] && ctl_q[BIT_REQ]) |->
      (pin_oe[PIN_REQ] && pin_out[PIN_REQ] == core_req_a));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && core_pin_in == '0));

endmodule

// File: tb/host_pin_mux_test.sv
`timescale 1ns/1ps
module host_pin_mux_test;

  localparam int EXTRA_W = 3;
  localparam int BUS_W   = 16;
  localparam int NP      = 5 + EXTRA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [BUS_W-1:0] reg_wdata = '0;
  logic [BUS_W-1:0] reg_rdata;
  logic bus_mux_mode = 1'b0;
  logic dual_request = 1'b0;
  logic core_req_a = 1'b0;
  logic core_req_b = 1'b0;
  logic [NP-1:0] core_pin_in;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_oe;
  logic [NP-1:0] pin_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  host_pin_mux #(.EXTRA_W(EXTRA_W), .BUS_W(BUS_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_mux_mode(bus_mux_mode),
    .dual_request(dual_request), .core_req_a(core_req_a), .core_req_b(core_req_b),
    .core_pin_in(core_pin_in), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  // reference registers
  logic [7:0] m_ctl;
  logic [NP-1:0] m_dir, m_dat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl <= 8'h00; m_dir <= '0; m_dat <= '0;
    end else if (reg_we) begin
      if (reg_addr == 2'd0) m_ctl <= reg_wdata[7:0] & 8'b0111_1110;
      if (reg_addr == 2'd1) m_dir <= reg_wdata[NP-1:0];
      if (reg_addr == 2'd2) m_dat <= reg_wdata[NP-1:0];
    end
  end

  // 0 = gpio, 1 = host input, 2 = host output
  function automatic int mrole(int p);
    if (!m_ctl[6]) return 0;
    case (p)
      0: return (bus_mux_mode && !m_ctl[1]) ? 0 : 1;
      1: return (bus_mux_mode && !m_ctl[2]) ? 0 : 1;
      2: return m_ctl[3] ? 1 : 0;
      3: return m_ctl[4] ? 2 : 0;
      4: begin
        if (!m_ctl[4]) return 0;
        if (dual_request) return 2;
        return m_ctl[5] ? 1 : 0;
      end
      default: return 1;
    endcase
  endfunction

  function automatic string rtag(int p);
    if (!m_ctl[6]) return "R3";
    if (p < 2) return "R4";
    if (p == 2) return "R5";
    if (p == 3) return m_ctl[4] ? "R6" : "R8";
    if (p == 4) return !m_ctl[4] ? "R8" : (dual_request ? "R7" : "R6");
    return "R12";
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [BUS_W-1:0] exp_rd;
    logic [NP-1:0] rd_bits, cin;
    rd_bits = '0; cin = '0;
    for (int p = 0; p < NP; p++) begin
      int r;
      logic e_oe, e_out;
      r = mrole(p);
      if (r == 0) begin
        e_oe = m_dir[p]; e_out = m_dat[p];
        rd_bits[p] = m_dir[p] ? m_dat[p] : pin_in[p];
      end else if (r == 1) begin
        e_oe = 1'b0; e_out = 1'b0; cin[p] = pin_in[p];
      end else begin
        e_oe = 1'b1; e_out = (p == 3) ? core_req_a : core_req_b;
      end
      chk(rtag(p), 64'(pin_oe[p]), 64'(e_oe));
      chk("R9", 64'(pin_out[p]), 64'(e_out));
    end
    chk("R11", 64'(core_pin_in), 64'(cin));
    case (reg_addr)
      2'd0: exp_rd = BUS_W'(m_ctl);
      2'd1: exp_rd = BUS_W'(m_dir);
      2'd2: exp_rd = BUS_W'(rd_bits);
      default: exp_rd = '0;
    endcase
    chk(reg_addr == 2'd2 ? "R10" : "R2", 64'(reg_rdata), 64'(exp_rd));
  endtask

  task automatic step(bit we, logic [1:0] a, logic [BUS_W-1:0] d);
    @(negedge clk);
    compare_all();
    reg_we = we; reg_addr = a; reg_wdata = d;
  endtask

  initial begin
    pin_in = 8'hA5;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", 64'(pin_oe), 64'd0);
    chk("R1", 64'(core_pin_in), 64'd0);
    chk("R1", 64'(reg_rdata), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 64'(pin_oe), 64'd0);
    reg_addr = 2'd1;
    #1 chk("R1", 64'(reg_rdata), 64'd0);
    // R2: reserved control bits read zero
    step(1'b1, 2'd0, 16'hFFFF);
    step(1'b0, 2'd0, 16'h0);
    step(1'b0, 2'd0, 16'h0);
    chk("R2", 64'(reg_rdata), 64'h7E);
    // R7: acknowledge enable ignored in double-request mode
    dual_request = 1'b1; core_req_b = 1'b1;
    step(1'b0, 2'd0, 16'h0);
    step(1'b0, 2'd3, 16'h0);
    chk("R7", 64'(pin_oe[4]), 64'd1);
    // R4: address enables clear in non-multiplexed mode
    bus_mux_mode = 1'b0;
    step(1'b1, 2'd0, 16'h0040);
    step(1'b0, 2'd2, 16'h0);
    chk("R4", 64'(core_pin_in[1:0]), 64'(pin_in[1:0]));
    // random traffic
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(15) == 0) bus_mux_mode = ~bus_mux_mode;
      if ($urandom_range(15) == 0) dual_request = ~dual_request;
      pin_in = NP'($urandom);
      core_req_a = 1'($urandom);
      core_req_b = 1'($urandom);
      step($urandom_range(3) == 0, 2'($urandom), BUS_W'($urandom));
    end
    step(1'b0, 2'd0, '0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule